// File: doc/BRIEF.md
# Fractional Position-to-Step Accumulator

This block turns a stream of signed position increments for one motion axis into single step pulses and a direction level for a stepper phase sequencer. Each accepted increment is multiplied by a steps-per-unit scale and added to a signed fixed-point accumulator that keeps the sub-step remainder from one update to the next. When the running total reaches a whole step, positive or negative, the block emits one step in that direction and takes one step's worth back out of the total.

Increments arrive with an axis tag and a valid strobe. Only increments whose tag equals the selected axis take part. A typical scale is 100 steps per unit. A single update never produces more than one step; any excess that is still past a threshold is carried and released by later updates, one step per update.

Top module: `ratchet_stepper`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `step_o` is 0, `dir_o` is 0 and the accumulator is zero, so a following small increment produces no step.
- R2: An accepted update adds `upd_delta_i * scale_i` to the accumulator, where `upd_delta_i` is two's complement with 16 fractional bits (65536 = one unit) and `scale_i` is an unsigned integer count of steps per unit.
- R3: If the updated total is at or above +1.0 step (65536), the block emits a step with `dir_o` = 1 and subtracts 65536.
- R4: If the updated total is at or below -1.0 step (-65536), the block emits a step with `dir_o` = 0 and adds 65536.
- R5: At most one step is emitted per accepted update; a total still beyond a threshold is kept, and each further accepted update (even with a zero increment) releases one more step.
- R6: An update whose `upd_axis_i` differs from `sel_axis_i`, or any cycle with `upd_valid_i` low, leaves the accumulator, `step_o` and `dir_o` unchanged apart from `step_o` returning to 0.
- R7: `step_o` is high for exactly the one clock cycle following the rising edge at which the triggering update was sampled, and only after an accepted update.
- R8: `dir_o` changes only together with a step and holds its value until the next step.
- R9: The accumulator saturates at the most positive and most negative values of its 32-bit range instead of wrapping.
- R10: The thresholds are inclusive: a total of exactly +65536 or -65536 steps, while 65535 or -65535 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid_i | input | 1 | Increment strobe |
| upd_axis_i | input | 2 | Axis tag of the increment |
| upd_delta_i | input | 24 | Signed increment, 16 fractional bits |
| sel_axis_i | input | 2 | Axis this instance follows |
| scale_i | input | 12 | Unsigned steps per unit |
| step_o | output | 1 | One-cycle step pulse |
| dir_o | output | 1 | Step direction, 1 = positive |

## Verification
The bench aims at the exact threshold values and one count below them, because an exclusive comparison would drop a step at exactly one unit and an off-by-one would step early. It builds up a total of several steps in one update and then sends zero increments, so a design that drained the whole excess at once, or forgot the carried remainder, would show the wrong number of pulses. Large increments at the full scale drive the total past both ends of its range; a wrapping adder would flip the sign and emit steps in the opposite direction. Updates for other axes and strobes held low are mixed in, where a design that accepted them would step or shift the later step timing.

// File: rtl/ratchet_pkg.sv
package ratchet_pkg;

    // Default geometry of the datapath
    localparam int unsigned DELTA_W_DEF = 24;
    localparam int unsigned FRAC_W_DEF  = 16;
    localparam int unsigned SCALE_W_DEF = 12;
    localparam int unsigned ACC_W_DEF   = 32;
    localparam int unsigned AXIS_W_DEF  = 2;

    // Direction of one emitted step
    typedef enum logic {
        DIR_NEG = 1'b0,
        DIR_POS = 1'b1
    } step_dir_e;

    // Decision taken for one accepted update
    typedef struct packed {
        logic      fire;
        step_dir_e dir;
    } step_cmd_t;

    // Width that holds the sum of two signed operands without overflow
    function automatic int unsigned sum_width(input int unsigned a, input int unsigned b);
        return ((a > b) ? a : b) + 1;
    endfunction

    // Width of a signed-by-unsigned product (unsigned operand gains a sign bit)
    function automatic int unsigned prod_width(input int unsigned sw, input int unsigned uw);
        return sw + uw + 1;
    endfunction

endpackage

// File: rtl/ratchet_gate.sv
module ratchet_gate
    import ratchet_pkg::*;
#(
    parameter int unsigned DELTA_W = DELTA_W_DEF,
    parameter int unsigned SCALE_W = SCALE_W_DEF,
    parameter int unsigned AXIS_W  = AXIS_W_DEF,
    localparam int unsigned PROD_W = prod_width(DELTA_W, SCALE_W)
) (
    input  logic                      valid_i,
    input  logic [AXIS_W-1:0]         axis_i,
    input  logic [AXIS_W-1:0]         sel_axis_i,
    input  logic signed [DELTA_W-1:0] delta_i,
    input  logic [SCALE_W-1:0]        scale_i,
    output logic                      accept_o,
    output logic signed [PROD_W-1:0]  product_o
);

    logic signed [PROD_W-1:0] delta_ext;
    logic signed [PROD_W-1:0] scale_ext;
    logic signed [PROD_W-1:0] raw_product;

    // Only the followed axis contributes
    assign accept_o = valid_i && (axis_i == sel_axis_i);

    // Sign-extend the increment, zero-extend the scale
    assign delta_ext = {{(PROD_W-DELTA_W){delta_i[DELTA_W-1]}}, delta_i};
    assign scale_ext = {{(PROD_W-SCALE_W){1'b0}}, scale_i};

    // The product fits PROD_W bits exactly
    assign raw_product = delta_ext * scale_ext;

    always_comb begin
        if (accept_o) begin
            product_o = raw_product;
        end else begin
            product_o = '0;
        end
    end

endmodule

// File: rtl/ratchet_satadd.sv
module ratchet_satadd
    import ratchet_pkg::*;
#(
    parameter int unsigned ACC_W  = ACC_W_DEF,
    parameter int unsigned PROD_W = prod_width(DELTA_W_DEF, SCALE_W_DEF),
    localparam int unsigned SUM_W = sum_width(ACC_W, PROD_W)
) (
    input  logic signed [ACC_W-1:0]  acc_i,
    input  logic signed [PROD_W-1:0] addend_i,
    output logic signed [ACC_W-1:0]  sum_o
);

    // Limits of the accumulator expressed in the wide sum width
    localparam logic signed [SUM_W-1:0] LIM_HI =
        {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] LIM_LO = ~LIM_HI;

    logic signed [SUM_W-1:0] acc_wide;
    logic signed [SUM_W-1:0] add_wide;
    logic signed [SUM_W-1:0] full_sum;

    generate
        if (SUM_W > PROD_W) begin : g_ext_add
            assign add_wide = {{(SUM_W-PROD_W){addend_i[PROD_W-1]}}, addend_i};
        end else begin : g_same_add
            assign add_wide = addend_i;
        end
        if (SUM_W > ACC_W) begin : g_ext_acc
            assign acc_wide = {{(SUM_W-ACC_W){acc_i[ACC_W-1]}}, acc_i};
        end else begin : g_same_acc
            assign acc_wide = acc_i;
        end
    endgenerate

    assign full_sum = acc_wide + add_wide;

    // Clamp instead of wrapping
    always_comb begin
        if (full_sum > LIM_HI) begin
            sum_o = LIM_HI[ACC_W-1:0];
        end else if (full_sum < LIM_LO) begin
            sum_o = LIM_LO[ACC_W-1:0];
        end else begin
            sum_o = full_sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/ratchet_thresh.sv
module ratchet_thresh
    import ratchet_pkg::*;
#(
    parameter int unsigned ACC_W  = ACC_W_DEF,
    parameter int unsigned FRAC_W = FRAC_W_DEF
) (
    input  logic signed [ACC_W-1:0] total_i,
    output step_cmd_t               cmd_o,
    output logic signed [ACC_W-1:0] remain_o
);

    // One whole step in the fixed-point format
    localparam logic signed [ACC_W-1:0] STEP_ONE =
        {{(ACC_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};
    localparam logic signed [ACC_W-1:0] STEP_NEG_ONE = -STEP_ONE;

    // Positive crossing is tested first; both cannot hold at once
    always_comb begin
        cmd_o    = '{fire: 1'b0, dir: DIR_NEG};
        remain_o = total_i;
        if (total_i >= STEP_ONE) begin
            cmd_o    = '{fire: 1'b1, dir: DIR_POS};
            remain_o = total_i - STEP_ONE;
        end else if (total_i <= STEP_NEG_ONE) begin
            cmd_o    = '{fire: 1'b1, dir: DIR_NEG};
            remain_o = total_i + STEP_ONE;
        end
    end

endmodule

// File: rtl/ratchet_stepper.sv
module ratchet_stepper
    import ratchet_pkg::*;
#(
    parameter int unsigned DELTA_W = DELTA_W_DEF,
    parameter int unsigned FRAC_W  = FRAC_W_DEF,
    parameter int unsigned SCALE_W = SCALE_W_DEF,
    parameter int unsigned ACC_W   = ACC_W_DEF,
    parameter int unsigned AXIS_W  = AXIS_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      upd_valid_i,
    input  logic [AXIS_W-1:0]         upd_axis_i,
    input  logic signed [DELTA_W-1:0] upd_delta_i,
    input  logic [AXIS_W-1:0]         sel_axis_i,
    input  logic [SCALE_W-1:0]        scale_i,
    output logic                      step_o,
    output logic                      dir_o
);

    localparam int unsigned PROD_W = prod_width(DELTA_W, SCALE_W);

    logic                      accept;
    logic signed [PROD_W-1:0]  product;
    logic signed [ACC_W-1:0]   acc_q;
    logic signed [ACC_W-1:0]   sum_sat;
    logic signed [ACC_W-1:0]   remain;
    step_cmd_t                 cmd;
    logic                      step_q;
    step_dir_e                 dir_q;

    ratchet_gate #(
        .DELTA_W (DELTA_W),
        .SCALE_W (SCALE_W),
        .AXIS_W  (AXIS_W)
    ) u_gate (
        .valid_i    (upd_valid_i),
        .axis_i     (upd_axis_i),
        .sel_axis_i (sel_axis_i),
        .delta_i    (upd_delta_i),
        .scale_i    (scale_i),
        .accept_o   (accept),
        .product_o  (product)
    );

    ratchet_satadd #(
        .ACC_W  (ACC_W),
        .PROD_W (PROD_W)
    ) u_add (
        .acc_i    (acc_q),
        .addend_i (product),
        .sum_o    (sum_sat)
    );

    ratchet_thresh #(
        .ACC_W  (ACC_W),
        .FRAC_W (FRAC_W)
    ) u_thr (
        .total_i  (sum_sat),
        .cmd_o    (cmd),
        .remain_o (remain)
    );

    // Accumulator and step outputs move only on accepted updates
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            step_q <= 1'b0;
            dir_q  <= DIR_NEG;
        end else begin
            step_q <= 1'b0;
            if (accept) begin
                acc_q  <= remain;
                step_q <= cmd.fire;
                if (cmd.fire) begin
                    dir_q <= cmd.dir;
                end
            end
        end
    end

    assign step_o = step_q;
    assign dir_o  = (dir_q == DIR_POS);

endmodule

// File: rtl/ratchet_chk.sv
module ratchet_chk #(
    parameter int unsigned ACC_W = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    accept,
    input logic signed [ACC_W-1:0] acc_q,
    input logic                    step_o,
    input logic                    dir_o
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!step_o && !dir_o && acc_q == '0));

    assert_pos_remainder_R3: assert property (@(posedge clk) disable iff (rst)
        (step_o && dir_o) |-> !acc_q[ACC_W-1]);

    assert_neg_remainder_R4: assert property (@(posedge clk) disable iff (rst)
        (step_o && !dir_o) |-> (acc_q[ACC_W-1] || acc_q == '0));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(accept)) |-> $stable(acc_q));

    assert_step_follows_update_R7: assert property (@(posedge clk) disable iff (rst)
        step_o |-> $past(accept));

    assert_dir_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !step_o) |-> $stable(dir_o));

endmodule

bind ratchet_stepper ratchet_chk #(.ACC_W(ACC_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .acc_q  (acc_q),
    .step_o (step_o),
    .dir_o  (dir_o)
);

// File: tb/tb_ratchet_stepper.sv
module tb_ratchet_stepper;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               upd_valid = 1'b0;
    logic [1:0]         upd_axis = 2'd0;
    logic signed [23:0] upd_delta = '0;
    logic [1:0]         sel_axis = 2'd1;
    logic [11:0]        scale = 12'd100;
    logic               step_o;
    logic               dir_o;

    int errors = 0;
    int checks = 0;

    // Reference state
    longint m_acc  = 0;
    bit     m_step = 0;
    bit     m_dir  = 0;

    localparam longint ONE    = 65536;
    localparam longint ACCMAX = 64'sd2147483647;
    localparam longint ACCMIN = -64'sd2147483648;

    always #10ns clk = ~clk;

    ratchet_stepper dut (
        .clk         (clk),
        .rst         (rst),
        .upd_valid_i (upd_valid),
        .upd_axis_i  (upd_axis),
        .upd_delta_i (upd_delta),
        .sel_axis_i  (sel_axis),
        .scale_i     (scale),
        .step_o      (step_o),
        .dir_o       (dir_o)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Called at a negative edge; returns at the following negative edge
    task automatic tick(input bit v, input logic [1:0] ax, input int d, input string tag);
        longint s;
        upd_valid = v;
        upd_axis  = ax;
        upd_delta = 24'(d);
        @(posedge clk);
        m_step = 0;
        if (v && ax == sel_axis) begin
            s = m_acc + longint'(d) * longint'(scale);
            if (s > ACCMAX) s = ACCMAX;
            if (s < ACCMIN) s = ACCMIN;
            if (s >= ONE) begin
                m_step = 1; m_dir = 1; s = s - ONE;
            end else if (s <= -ONE) begin
                m_step = 1; m_dir = 0; s = s + ONE;
            end
            m_acc = s;
        end
        @(negedge clk);
        upd_valid = 1'b0;
        check(tag, "step_o", longint'(step_o), longint'(m_step));
        check(tag, "dir_o",  longint'(dir_o),  longint'(m_dir));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        upd_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", "step_o in reset", longint'(step_o), 0);
        check("R1", "dir_o in reset",  longint'(dir_o),  0);
        rst = 1'b0;
        m_acc = 0; m_step = 0; m_dir = 0;
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        do_reset();
        // R1: small increment right after reset gives no step
        tick(1, 2'd1, 300, "R1");

        // R2: sub-step increments accumulate, step on third
        do_reset();
        for (int i = 0; i < 4; i++) tick(1, 2'd1, 262, "R2");
        for (int i = 0; i < 3; i++) tick(1, 2'd1, -262, "R2");

        // R10 and R3/R4 at exact thresholds, scale 1
        do_reset();
        scale = 12'd1;
        tick(1, 2'd1, 65535, "R10");
        tick(1, 2'd1, 1, "R3");
        tick(1, 2'd1, -65535, "R10");
        tick(1, 2'd1, -1, "R4");
        tick(0, 2'd1, 0, "R8");
        tick(1, 2'd1, 65536, "R10");
        tick(1, 2'd1, -65536, "R10");
        tick(1, 2'd1, -65536, "R4");
        for (int i = 0; i < 3; i++) tick(0, 2'd1, 0, "R8");

        // R5: five steps in one update released one per update
        do_reset();
        scale = 12'd100;
        tick(1, 2'd1, 3277, "R5");
        for (int i = 0; i < 6; i++) tick(1, 2'd1, 0, "R5");
        tick(1, 2'd1, -3277, "R5");
        for (int i = 0; i < 6; i++) tick(1, 2'd1, 0, "R5");

        // R6: other axis and low strobe have no effect, probed with zero updates
        do_reset();
        tick(1, 2'd2, 30000, "R6");
        tick(1, 2'd1, 0, "R6");
        tick(0, 2'd1, 30000, "R6");
        tick(1, 2'd1, 0, "R6");
        tick(1, 2'd0, -30000, "R6");
        tick(1, 2'd1, 655, "R6");
        tick(1, 2'd1, 0, "R6");

        // R7: back-to-back steps then idle gap
        tick(1, 2'd1, 1000, "R7");
        tick(1, 2'd1, 1000, "R7");
        tick(0, 2'd1, 0, "R7");
        tick(0, 2'd1, 0, "R7");

        // R9: saturation at both ends
        do_reset();
        scale = 12'd4095;
        tick(1, 2'd1, 8388607, "R9");
        scale = 12'd1;
        for (int i = 0; i < 3; i++) tick(1, 2'd1, 0, "R9");
        tick(1, 2'd1, -8388608, "R9");
        do_reset();
        scale = 12'd4095;
        tick(1, 2'd1, -8388608, "R9");
        tick(1, 2'd1, -8388608, "R9");
        for (int i = 0; i < 3; i++) tick(1, 2'd1, 0, "R9");

        // Mixed pseudo-random traffic, R2/R6 under load
        do_reset();
        scale = 12'd100;
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick(lfsr[14] | lfsr[15], lfsr[13:12],
                 int'($signed(lfsr[11:0])) * 3, "R2");
        end
        sel_axis = 2'd3;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick(1, lfsr[1:0], int'($signed(lfsr[15:4])) * 5, "R6");
        end

        finish_run();
    end

endmodule